// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial-bus slave that holds six 8-bit configuration registers. Their contents appear on a parallel output. An internal system clock samples the bus clock (SCL) and data (SDA) lines. The block recognises start, repeated start and stop conditions. It pulls SDA low through an open-drain enable, both to acknowledge and to send zero data bits. It does not stretch the clock, and it has no packet error code.

The command byte chooses how the registers are reached:

- **Indexed single-byte access.** The command byte's top bit is 1, and its low seven bits name the offset. A byte write or a byte read then touches that one register.
- **Sequential block access.** The command byte's top bit is 0. The access then always begins at offset 0.
  - A block write sends a count byte first. The slave accepts the count but does not use it.
  - A block read returns a count of 6 first, then the registers in ascending order.
  - The master may end a block transfer after any complete byte.

One offset, offset 4, holds a fixed revision/vendor code and cannot be written.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1101110, written as DCh for write and DDh for read. It gives no acknowledge to any other address, and it keeps SDA released until the next start condition.
- R2: Command bit 7 = 1 selects a single-byte access at the offset held in command bits 6:0. Command bit 7 = 0 selects a block access that starts at offset 0.
- R3: A byte write stores the data byte in the addressed register. Register k appears on cfg_o[8k+7:8k], and no other register changes.
- R4: A block write acknowledges the count byte, then stores the data bytes into offsets 0, 1, 2 and so on. A stop after any complete byte leaves the registers that were not reached unchanged.
- R5: A byte read takes the form write address, command, repeated start, read address. It returns the addressed register, most significant bit first.
- R6: A block read first returns the count 6, then registers 0 to 5 in ascending order for as long as the master acknowledges. A master not-acknowledge ends the transfer.
- R7: After reset the registers hold 0x07, 0xFF, 0x00, 0x00, 0x08 and 0x00 for offsets 0 to 5.
- R8: Offset 4 is read-only and always holds 0x08. A write to offset 4, or to any offset above 5, is acknowledged and has no effect. A read of an offset above 5 returns 0x00.
- R9: The SDA drive changes only while the synchronised SCL is low. SDA is pulled low only during an acknowledge or a zero data bit, and never while the slave is idle.
- R10: A start or repeated start at any point restarts address reception. A stop at any point returns the slave to idle.
- R11: Register contents change only on a falling edge of the synchronised SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 48 | Register contents; offset k occupies bits 8k+7:8k |

## Verification
The checks on SDA drive and start handling assume a well-behaved master. Such a master changes SDA only in the middle of the SCL low phase, and issues a stop or start only while the slave is not driving the line. They also assume each SCL phase lasts many system clocks, so the synchronised edges never merge. The stimulus holds each SCL phase for twenty system clocks and moves SDA ten clocks into the low phase. It issues every stop and repeated start right after an acknowledge cycle from the master, or while the slave has already released the line.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OFF_W    = 7;
  localparam int unsigned RO_INDEX = 4;
  localparam logic [7:0]  RO_VALUE = 8'h08;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } smb_st_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_DATA
  } smb_role_e;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       reg_default = 8'h07;
      1:       reg_default = 8'hFF;
      RO_INDEX: reg_default = RO_VALUE;
      default: reg_default = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lv,
  output logic sda_lv,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh_q, scl_sh_d;
  logic [DEPTH-1:0] sda_sh_q, sda_sh_d;
  logic scl_pv, sda_pv;

  always_comb begin
    scl_sh_d = {scl_sh_q[DEPTH-2:0], scl_i};
    sda_sh_d = {sda_sh_q[DEPTH-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
    end
  end

  assign scl_lv    = scl_sh_q[STAGES-1];
  assign scl_pv    = scl_sh_q[STAGES];
  assign sda_lv    = sda_sh_q[STAGES-1];
  assign sda_pv    = sda_sh_q[STAGES];
  assign scl_rise  = scl_lv & ~scl_pv;
  assign scl_fall  = ~scl_lv & scl_pv;
  assign start_det = scl_lv & scl_pv & sda_pv & ~sda_lv;
  assign stop_det  = scl_lv & scl_pv & ~sda_pv & sda_lv;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter int unsigned N_REGS = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [OFF_W-1:0]         wr_off,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [OFF_W-1:0]         rd_off,
  output logic [BYTE_W-1:0]        rd_data,
  output logic [N_REGS*BYTE_W-1:0] cfg_o
);
  logic [BYTE_W-1:0] regs [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    if (g == RO_INDEX) begin : g_ro
      assign regs[g] = RO_VALUE;
    end else begin : g_rw
      logic             sel;
      logic [BYTE_W-1:0] val_q;
      assign sel = wr_en && (wr_off == OFF_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= reg_default(g);
        else if (sel) val_q <= wr_data;
      end
      assign regs[g] = val_q;
    end
    assign cfg_o[g*BYTE_W +: BYTE_W] = regs[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (rd_off == OFF_W'(i)) rd_data = regs[i];
    end
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h6E,
  parameter int unsigned N_REGS      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  output logic [N_REGS*BYTE_W-1:0] cfg_o
);
  localparam int unsigned BC_W  = $clog2(BYTE_W + 1);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic scl_lv, sda_lv, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lv(scl_lv), .sda_lv(sda_lv), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  smb_st_e          st_q, st_d;
  smb_role_e        role_q, role_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [OFF_W-1:0]  ptr_q, ptr_d;
  logic blk_q, blk_d, go_tx_q, go_tx_d, cnt_pend_q, cnt_pend_d;
  logic mack_q, mack_d, oe_q, oe_d;
  logic              wr_en;
  logic [BYTE_W-1:0] rd_data;

  smb_reg_bank #(.N_REGS(N_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(ptr_q),
    .wr_data(sh_q), .rd_off(ptr_q), .rd_data(rd_data), .cfg_o(cfg_o)
  );

  function automatic logic [OFF_W-1:0] ptr_inc(input logic [OFF_W-1:0] p);
    ptr_inc = (p == OFF_MAX) ? p : p + 1'b1;
  endfunction

  always_comb begin
    st_d       = st_q;
    role_d     = role_q;
    sh_d       = sh_q;
    bc_d       = bc_q;
    ptr_d      = ptr_q;
    blk_d      = blk_q;
    go_tx_d    = go_tx_q;
    cnt_pend_d = cnt_pend_q;
    mack_d     = mack_q;
    oe_d       = oe_q;
    wr_en      = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d    = ST_RX;
      role_d  = RL_ADDR;
      bc_d    = '0;
      go_tx_d = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: oe_d = 1'b0;
        ST_RX: begin
          oe_d = 1'b0;
          if (scl_rise && bc_q < BC_W'(BYTE_W)) begin
            sh_d = {sh_q[BYTE_W-2:0], sda_lv};
            bc_d = bc_q + 1'b1;
          end else if (scl_fall && bc_q == BC_W'(BYTE_W)) begin
            st_d = ST_ACK;
            oe_d = 1'b1;
            case (role_q)
              RL_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  go_tx_d    = sh_q[0];
                  cnt_pend_d = sh_q[0] & blk_q;
                  role_d     = RL_CMD;
                end else begin
                  st_d = ST_IDLE;
                  oe_d = 1'b0;
                end
              end
              RL_CMD: begin
                blk_d  = ~sh_q[7];
                ptr_d  = sh_q[7] ? sh_q[OFF_W-1:0] : '0;
                role_d = sh_q[7] ? RL_DATA : RL_CNT;
              end
              RL_CNT: role_d = RL_DATA;
              default: begin
                wr_en = 1'b1;
                ptr_d = ptr_inc(ptr_q);
              end
            endcase
          end
        end
        ST_ACK: begin
          oe_d = 1'b1;
          if (scl_fall) begin
            bc_d = '0;
            if (go_tx_q) begin
              st_d = ST_TX;
              if (cnt_pend_q) begin
                sh_d       = BYTE_W'(N_REGS);
                cnt_pend_d = 1'b0;
              end else begin
                sh_d  = rd_data;
                ptr_d = ptr_inc(ptr_q);
              end
              oe_d = ~sh_d[BYTE_W-1];
            end else begin
              st_d = ST_RX;
              oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          oe_d = ~sh_q[BYTE_W-1];
          if (scl_fall) begin
            if (bc_q == BC_W'(BYTE_W - 1)) begin
              st_d = ST_TXACK;
              oe_d = 1'b0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              bc_d = bc_q + 1'b1;
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_TXACK: begin
          oe_d = 1'b0;
          if (scl_rise) mack_d = ~sda_lv;
          if (scl_fall) begin
            bc_d = '0;
            if (mack_q) begin
              st_d = ST_TX;
              if (cnt_pend_q) begin
                sh_d       = BYTE_W'(N_REGS);
                cnt_pend_d = 1'b0;
              end else begin
                sh_d  = rd_data;
                ptr_d = ptr_inc(ptr_q);
              end
              oe_d = ~sh_d[BYTE_W-1];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      role_q     <= RL_ADDR;
      sh_q       <= '0;
      bc_q       <= '0;
      ptr_q      <= '0;
      blk_q      <= 1'b0;
      go_tx_q    <= 1'b0;
      cnt_pend_q <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      role_q     <= role_d;
      sh_q       <= sh_d;
      bc_q       <= bc_d;
      ptr_q      <= ptr_d;
      blk_q      <= blk_d;
      go_tx_q    <= go_tx_d;
      cnt_pend_q <= cnt_pend_d;
      mack_q     <= mack_d;
      oe_q       <= oe_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smb_cfg_pkg::*;
#(
  parameter int unsigned N_REGS = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_lv,
  input logic                     scl_fall,
  input logic                     start_det,
  input logic                     sda_oe,
  input logic [N_REGS*BYTE_W-1:0] cfg_o,
  input smb_st_e                  st
);
  // R9: drive is frozen while synchronised SCL stays high
  a_r9_drive_frozen_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lv && $past(scl_lv)) |-> $stable(sda_oe));

  // R9: idle slave never pulls the line
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R9: pulling low happens only in acknowledge or transmit states
  a_r9_drive_in_ack_or_tx: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == ST_ACK || st == ST_TX));

  // R11: register contents move only after a synchronised falling SCL
  a_r11_cfg_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(scl_fall));

  // R10: a start condition re-arms address reception
  a_r10_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> (st == ST_RX));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.N_REGS(N_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lv(scl_lv), .scl_fall(scl_fall),
  .start_det(start_det), .sda_oe(sda_oe), .cfg_o(cfg_o), .st(st_q)
);

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
module tb_smb_cfg_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe;
  logic [47:0] cfg_o;
  wire  sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smb_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_reg [6];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rd_val;
  event       rd_ev;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_check(input string req);
    for (int i = 0; i < 6; i++)
      chk(cfg_o[i*8 +: 8] === exp_reg[i], req, cfg_o[i*8 +: 8], exp_reg[i]);
  endtask

  task automatic bit_cycle(input logic b, output logic r);
    wclk(H); sda_m = b; wclk(H); scl_m = 1'b1;
    wclk(H); r = sda_bus; wclk(H); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wclk(2*H); scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    wclk(H); sda_m = 1'b1; wclk(H); scl_m = 1'b1;
    wclk(2*H); sda_m = 1'b0; wclk(2*H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(H); sda_m = 1'b0; wclk(H); scl_m = 1'b1;
    wclk(2*H); sda_m = 1'b1; wclk(2*H);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_cycle(v[i], r);
    bit_cycle(1'b1, r);
    acked = (r == 1'b0);
  endtask

  task automatic rd_byte(input bit ack);
    logic r;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r);
      v[i] = r;
    end
    bit_cycle(ack ? 1'b0 : 1'b1, r);
    rd_val = v;
    ->rd_ev;
    wclk(1);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", rd_val, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_val === e, t, rd_val, e);
      end
    end
  end

  task automatic byte_write(input logic [6:0] off, input logic [7:0] v, input string req);
    bit a0, a1, a2;
    bus_start();
    wr_byte(8'hDC, a0); wr_byte({1'b1, off}, a1); wr_byte(v, a2);
    bus_stop();
    chk(a0 && a1 && a2, req, {a0, a1, a2}, 3'b111);
  endtask

  task automatic byte_read(input logic [6:0] off, input logic [7:0] e, input string req);
    bit a0, a1, a2;
    bus_start();
    wr_byte(8'hDC, a0); wr_byte({1'b1, off}, a1);
    bus_rstart();
    wr_byte(8'hDD, a2);
    chk(a0 && a1 && a2, req, {a0, a1, a2}, 3'b111);
    expect_byte(e, req);
    rd_byte(1'b0);
    bus_stop();
  endtask

  initial begin
    wclk(150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit a;
    exp_reg = '{8'h07, 8'hFF, 8'h00, 8'h00, 8'h08, 8'h00};
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    wclk(5); rst_n = 1'b1; wclk(5);

    // R7: reset values, R9: released
    cfg_check("R7");
    chk(sda_oe == 1'b0, "R9", sda_oe, 0);

    // R1: foreign address is not acknowledged, nor is a following byte
    bus_start();
    wr_byte(8'hA0, a); chk(!a, "R1", a, 0);
    wr_byte(8'h82, a); chk(!a, "R1", a, 0);
    bus_stop();
    cfg_check("R1");

    // R3/R2: byte write to offset 2
    byte_write(7'd2, 8'h5A, "R3");
    exp_reg[2] = 8'h5A;
    cfg_check("R3");
    chk(sda_oe == 1'b0, "R9", sda_oe, 0);

    // R5: byte read of offset 1 and offset 2
    byte_read(7'd1, 8'hFF, "R5");
    byte_read(7'd2, 8'h5A, "R5");

    // R8: read-only offset and out-of-range offsets
    byte_write(7'd4, 8'h77, "R8");
    cfg_check("R8");
    byte_read(7'd4, 8'h08, "R8");
    byte_write(7'd16, 8'hC3, "R8");
    cfg_check("R8");
    byte_read(7'd16, 8'h00, "R8");

    // R4/R2: full block write from offset 0
    begin
      bit ok;
      logic [7:0] d [6];
      d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
      ok = 1;
      bus_start();
      wr_byte(8'hDC, a); ok &= a;
      wr_byte(8'h00, a); ok &= a;
      wr_byte(8'h06, a); ok &= a;
      for (int i = 0; i < 6; i++) begin
        wr_byte(d[i], a); ok &= a;
        if (i != 4) exp_reg[i] = d[i];
      end
      bus_stop();
      chk(ok, "R4", ok, 1);
      cfg_check("R4");
    end

    // R4: block write stopped after two data bytes
    bus_start();
    wr_byte(8'hDC, a); wr_byte(8'h00, a); wr_byte(8'h06, a);
    wr_byte(8'hA1, a); wr_byte(8'hA2, a);
    bus_stop();
    exp_reg[0] = 8'hA1; exp_reg[1] = 8'hA2;
    cfg_check("R4");

    // R6: full block read, count first then ascending registers
    bus_start();
    wr_byte(8'hDC, a); wr_byte(8'h00, a);
    bus_rstart();
    wr_byte(8'hDD, a); chk(a, "R6", a, 1);
    expect_byte(8'h06, "R6");
    rd_byte(1'b1);
    for (int i = 0; i < 6; i++) begin
      expect_byte(exp_reg[i], "R6");
      rd_byte(i != 5);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R9", sda_oe, 0);

    // R6: block read ended early by master
    bus_start();
    wr_byte(8'hDC, a); wr_byte(8'h00, a);
    bus_rstart();
    wr_byte(8'hDD, a);
    expect_byte(8'h06, "R6");
    rd_byte(1'b1);
    expect_byte(exp_reg[0], "R6");
    rd_byte(1'b0);
    bus_stop();
    chk(sda_oe == 1'b0, "R6", sda_oe, 0);

    // R10: repeated start abandons the first command
    bus_start();
    wr_byte(8'hDC, a); wr_byte(8'h83, a);
    bus_rstart();
    wr_byte(8'hDC, a); wr_byte(8'h85, a); wr_byte(8'h9C, a);
    bus_stop();
    exp_reg[5] = 8'h9C;
    cfg_check("R10");

    wclk(20);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    summary();
  end
endmodule